// File: doc/BRIEF.md
# Double-Compare Key Matrix Scanner

This block watches a key matrix of up to six drive lines and five sense lines. The sense lines have pull-downs. While no scan is running, every drive line in use sits high, so any pressed key pulls a sense line high. That press starts a pair of back-to-back scans. A scan drives one line at a time and samples the five sense lines at the end of that line's slot. If the two scans agree and at least one key is seen, the result is latched into a 30-bit key vector and an active-low read request is raised. Scanning then stops until the host signals that its read is finished. If the two scans disagree while a key is still seen, a fresh pair of scans runs. The pairing filters out contact bounce.

A 2-bit key-count select reduces the matrix to 25 or 20 keys by taking the lowest one or two drive lines out of use. A 2-bit power-save select changes which lines idle high, and so which keys can be read. A host write frame, seen as chip enable high, hides a pending request for as long as the frame lasts. All timing advances on a clock-enable pulse at the scan rate.

FSM states: IDLE (lines at idle levels, waiting for a press), SCAN_A (first scan), SCAN_B (second scan), CMP (one-tick comparison), HOLD (result latched, request pending).

Transitions:
- IDLE→SCAN_A on a tick with any sense line high.
- SCAN_A→SCAN_B at the last sample of the first scan.
- SCAN_B→CMP at the last sample of the second scan.
- CMP→HOLD on a tick when the two scans match and are non-empty.
- CMP→SCAN_A on a tick when they differ and the second scan is non-empty.
- CMP→IDLE on a tick when the second scan is empty.
- HOLD→IDLE on the read-done strobe.

Top module: `keymatrix_scanner`

## Requirements
- R1: A scan lasts 288 ticks and is made of six 48-tick slots. In slot i only drive line i is high, and only if that line is in use. Counting advances only on clock cycles with the tick input high.
- R2: On a tick in IDLE with any sense line high, scanning starts. When the two scans match and are non-empty, the request output goes low exactly 577 ticks after the starting tick.
- R3: When the two scans differ and the second one is non-empty, another pair of scans runs. With one such rescan, the request falls 1154 ticks after the starting tick.
- R4: When the second scan of a pair sees no key, the block returns to IDLE. No request is raised and the key vector keeps its previous value.
- R5: While the request is pending, no scan runs, the drive lines sit at their idle levels, and the key vector does not change whatever the sense lines do.
- R6: A read-done pulse while the request is pending returns the request high on the next clock and re-enables scanning. A read-done pulse at any other time has no effect.
- R7: Key-count select 00 gives 30 keys. Select 01 gives 25 keys: drive line 0 is unused and key bits 4..0 read 0. Select 1x gives 20 keys: lines 0 and 1 are unused and bits 9..0 read 0. Unused lines are always driven low.
- R8: Key bit 5*i+j of the key vector is the key on drive line i and sense line j, with 1 meaning pressed.
- R9: Power-save select values:
  - 00: normal.
  - 01: only line 5 is in use.
  - 10: only lines 4 and 5 are in use.
  - 11: all lines are in use.
  The power-save flag is high for any non-zero select. Lines not in use idle low and their key bits read 0.
- R10: While the chip-enable input is high, the request output reads high even when a request is pending. It falls again when chip enable drops while the request is still pending.
- R11: Reset clears the key vector to zero, sets the request high and leaves the block in IDLE.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Clock enable at the scan rate |
| sense | input | 5 | Matrix sense lines, pulled low, high for a pressed key on a driven line |
| key_sel | input | 2 | Key-count select (00: 30, 01: 25, 1x: 20) |
| save_sel | input | 2 | Power-save select |
| read_done | input | 1 | One-clock strobe: host read of the key data finished |
| host_cs | input | 1 | Chip enable of a host write frame |
| drive | output | 6 | Matrix drive lines |
| keys | output | 30 | Latched key vector |
| save_flag | output | 1 | High in any power-save mode |
| req_n | output | 1 | Active-low read request |

## Verification
The bench tries several input patterns.
- Clean single presses show the 577-tick latency and the bit mapping.
- A key that changes between the first and second scan must cost exactly one extra pair of scans.
- A key released before the second scan must produce no request.
- Presses on lines that are out of use under each key-count and power-save setting must not start a scan and must not appear in the key vector.
- Sense activity during a pending request must leave the latched data alone.

A tick that arrives only every third clock separates true tick gating from counting of raw clocks.

// File: rtl/kscan_pkg.sv
package kscan_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SCAN_A,
        ST_SCAN_B,
        ST_CMP,
        ST_HOLD
    } kscan_state_e;

    localparam logic [1:0] SAVE_ONE = 2'b01;
    localparam logic [1:0] SAVE_TWO = 2'b10;

    // Whether drive line idx takes part in scanning for the given selects.
    function automatic logic line_in_use(input int idx, input int lines,
                                         input logic [1:0] ksel,
                                         input logic [1:0] ssel);
        logic cnt_ok;
        logic save_ok;
        if (ksel[1])
            cnt_ok = (idx >= 2);
        else if (ksel[0])
            cnt_ok = (idx >= 1);
        else
            cnt_ok = 1'b1;
        unique case (ssel)
            SAVE_ONE: save_ok = (idx == lines - 1);
            SAVE_TWO: save_ok = (idx >= lines - 2);
            default:  save_ok = 1'b1;
        endcase
        return cnt_ok & save_ok;
    endfunction

endpackage

// File: rtl/kscan_line_cfg.sv
module kscan_line_cfg #(
    parameter int DRV_LINES = 6
) (
    input  logic [1:0]           key_sel,
    input  logic [1:0]           save_sel,
    output logic [DRV_LINES-1:0] line_valid,
    output logic                 save_flag
);
    import kscan_pkg::*;

    for (genvar g = 0; g < DRV_LINES; g++) begin : g_line
        assign line_valid[g] = line_in_use(g, DRV_LINES, key_sel, save_sel);
    end

    assign save_flag = |save_sel;

endmodule

// File: rtl/kscan_timer.sv
module kscan_timer #(
    parameter int DRV_LINES  = 6,
    parameter int LINE_TICKS = 48,
    parameter int LINE_W     = $clog2(DRV_LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              run,
    output logic [LINE_W-1:0] line_idx,
    output logic              sample,
    output logic              last
);
    localparam int SW = (LINE_TICKS > 1) ? $clog2(LINE_TICKS) : 1;

    logic [SW-1:0]     slot;
    logic [LINE_W-1:0] line;
    logic              slot_end;
    logic              line_end;

    assign slot_end = (slot == SW'(LINE_TICKS - 1));
    assign line_end = (line == LINE_W'(DRV_LINES - 1));
    assign sample   = run & tick & slot_end;
    assign last     = sample & line_end;
    assign line_idx = line;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot <= '0;
            line <= '0;
        end else if (!run) begin
            slot <= '0;
            line <= '0;
        end else if (tick) begin
            if (slot_end) begin
                slot <= '0;
                line <= line_end ? '0 : line + 1'b1;
            end else begin
                slot <= slot + 1'b1;
            end
        end
    end

endmodule

// File: rtl/kscan_capture.sv
module kscan_capture #(
    parameter int DRV_LINES = 6,
    parameter int SNS_LINES = 5,
    parameter int LINE_W    = $clog2(DRV_LINES),
    parameter int KEYS      = DRV_LINES * SNS_LINES
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sample,
    input  logic [LINE_W-1:0]    line_idx,
    input  logic [SNS_LINES-1:0] sense,
    input  logic [DRV_LINES-1:0] line_valid,
    input  logic                 save_first,
    output logic [KEYS-1:0]      scan_now,
    output logic [KEYS-1:0]      scan_first
);
    logic [KEYS-1:0] cur;
    logic [KEYS-1:0] first;

    // Current scan image with this cycle's sample merged in.
    always_comb begin
        scan_now = cur;
        for (int i = 0; i < DRV_LINES; i++) begin
            if (sample && line_idx == LINE_W'(i))
                scan_now[i*SNS_LINES +: SNS_LINES] = line_valid[i] ? sense : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur   <= '0;
            first <= '0;
        end else begin
            cur <= scan_now;
            if (save_first)
                first <= scan_now;
        end
    end

    assign scan_first = first;

endmodule

// File: rtl/keymatrix_scanner.sv
module keymatrix_scanner #(
    parameter int DRV_LINES  = 6,
    parameter int SNS_LINES  = 5,
    parameter int LINE_TICKS = 48
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           tick,
    input  logic [SNS_LINES-1:0]           sense,
    input  logic [1:0]                     key_sel,
    input  logic [1:0]                     save_sel,
    input  logic                           read_done,
    input  logic                           host_cs,
    output logic [DRV_LINES-1:0]           drive,
    output logic [DRV_LINES*SNS_LINES-1:0] keys,
    output logic                           save_flag,
    output logic                           req_n
);
    import kscan_pkg::*;

    localparam int KEYS   = DRV_LINES * SNS_LINES;
    localparam int LINE_W = (DRV_LINES > 1) ? $clog2(DRV_LINES) : 1;

    kscan_state_e          state;
    kscan_state_e          state_nx;
    logic [DRV_LINES-1:0]  line_valid;
    logic [LINE_W-1:0]     line_idx;
    logic                  sample;
    logic                  last;
    logic                  run;
    logic                  save_first;
    logic [KEYS-1:0]       scan_now;
    logic [KEYS-1:0]       scan_first;
    logic                  any_now;
    logic                  pair_match;

    kscan_line_cfg #(.DRV_LINES(DRV_LINES)) u_cfg (
        .key_sel    (key_sel),
        .save_sel   (save_sel),
        .line_valid (line_valid),
        .save_flag  (save_flag)
    );

    kscan_timer #(
        .DRV_LINES  (DRV_LINES),
        .LINE_TICKS (LINE_TICKS),
        .LINE_W     (LINE_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .run      (run),
        .line_idx (line_idx),
        .sample   (sample),
        .last     (last)
    );

    kscan_capture #(
        .DRV_LINES (DRV_LINES),
        .SNS_LINES (SNS_LINES),
        .LINE_W    (LINE_W),
        .KEYS      (KEYS)
    ) u_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .sample     (sample),
        .line_idx   (line_idx),
        .sense      (sense),
        .line_valid (line_valid),
        .save_first (save_first),
        .scan_now   (scan_now),
        .scan_first (scan_first)
    );

    assign run        = (state == ST_SCAN_A) || (state == ST_SCAN_B);
    assign save_first = (state == ST_SCAN_A) && last;
    assign any_now    = |scan_now;
    assign pair_match = (scan_now == scan_first);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nx;
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (tick && |sense) state_nx = ST_SCAN_A;
            ST_SCAN_A: if (last) state_nx = ST_SCAN_B;
            ST_SCAN_B: if (last) state_nx = ST_CMP;
            ST_CMP: begin
                if (tick) begin
                    if (pair_match && any_now)
                        state_nx = ST_HOLD;
                    else if (any_now)
                        state_nx = ST_SCAN_A;
                    else
                        state_nx = ST_IDLE;
                end
            end
            ST_HOLD:   if (read_done) state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // Confirmed key vector
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            keys <= '0;
        else if (state == ST_CMP && state_nx == ST_HOLD)
            keys <= scan_now;
    end

    // Outputs
    always_comb begin
        unique case (state)
            ST_SCAN_A, ST_SCAN_B:
                drive = line_valid & (DRV_LINES'(1) << line_idx);
            ST_CMP:
                drive = '0;
            default:
                drive = line_valid;
        endcase
        req_n = (state != ST_HOLD) || host_cs;
    end

endmodule

// File: rtl/keymatrix_scanner_chk.sv
module keymatrix_scanner_chk
    import kscan_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input kscan_state_e       state,
    input logic [5:0]         drive,
    input logic [29:0]        keys,
    input logic [1:0]         key_sel,
    input logic [1:0]         save_sel,
    input logic               read_done,
    input logic               host_cs,
    input logic               req_n
);

    p_scan_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SCAN_A || state == ST_SCAN_B) |-> $onehot0(drive));

    p_hold_after_cmp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && $past(state) != ST_HOLD) |-> $past(state) == ST_CMP);

    p_keys_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && $past(state) == ST_HOLD) |-> $stable(keys));

    p_read_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && read_done) |=> (state == ST_IDLE && req_n));

    p_count25_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && $past(state) == ST_CMP && $past(key_sel) == 2'b01)
            |-> keys[4:0] == 5'b0);

    p_count20_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && $past(state) == ST_CMP && $past(key_sel[1]))
            |-> keys[9:0] == 10'b0);

    p_save1_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && save_sel == 2'b01) |-> drive[4:0] == 5'b0);

    p_cs_hides_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        host_cs |-> req_n);

endmodule

bind keymatrix_scanner keymatrix_scanner_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .state     (state),
    .drive     (drive),
    .keys      (keys),
    .key_sel   (key_sel),
    .save_sel  (save_sel),
    .read_done (read_done),
    .host_cs   (host_cs),
    .req_n     (req_n)
);

// File: tb/keymatrix_scanner_test.sv
module keymatrix_scanner_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        tick = 1'b0;
    logic [4:0]  sense;
    logic [1:0]  key_sel;
    logic [1:0]  save_sel;
    logic        read_done;
    logic        host_cs;
    logic [5:0]  drive;
    logic [29:0] keys;
    logic        save_flag;
    logic        req_n;

    logic [29:0] pressed;
    int          tick_div = 1;
    int          tick_cnt = 0;
    int          n_chk = 0;
    int          n_err = 0;
    bit          cmp_on = 1'b0;

    always #5 clk = ~clk;

    keymatrix_scanner uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .sense     (sense),
        .key_sel   (key_sel),
        .save_sel  (save_sel),
        .read_done (read_done),
        .host_cs   (host_cs),
        .drive     (drive),
        .keys      (keys),
        .save_flag (save_flag),
        .req_n     (req_n)
    );

    // Passive key matrix with pull-downs
    always_comb begin
        sense = '0;
        for (int i = 0; i < 6; i++)
            for (int j = 0; j < 5; j++)
                if (drive[i] && pressed[i*5+j]) sense[j] = 1'b1;
    end

    always @(negedge clk) begin
        tick     <= (tick_cnt % tick_div) == 0;
        tick_cnt <= tick_cnt + 1;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // ---------------- reference model ----------------
    function automatic bit m_valid(input int i);
        bit c;
        bit s;
        c = (key_sel == 2'b00) || (key_sel == 2'b01 && i > 0) || (key_sel[1] && i > 1);
        if (save_sel == 2'b01)      s = (i == 5);
        else if (save_sel == 2'b10) s = (i >= 4);
        else                        s = 1'b1;
        return c && s;
    endfunction

    int          m_st;     // 0 idle, 1 scanning, 2 compare, 3 pending
    int          m_c;      // ticks into the scan pair, 0..575
    logic [29:0] m_cur, m_first, m_keys, m_nxt;
    int          m_ln;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st <= 0; m_c <= 0; m_cur <= '0; m_first <= '0; m_keys <= '0;
        end else begin
            if (m_st == 1 && tick) begin
                m_nxt = m_cur;
                if (m_c % 48 == 47) begin
                    m_ln = (m_c % 288) / 48;
                    for (int j = 0; j < 5; j++)
                        m_nxt[m_ln*5+j] = m_valid(m_ln) ? sense[j] : 1'b0;
                end
                m_cur <= m_nxt;
                if (m_c == 287) m_first <= m_nxt;
                if (m_c == 575) begin m_st <= 2; m_c <= 0; end
                else m_c <= m_c + 1;
            end else if (m_st == 0 && tick && sense != 0) begin
                m_st <= 1; m_c <= 0;
            end else if (m_st == 2 && tick) begin
                if (m_cur == m_first && m_cur != 0) begin m_st <= 3; m_keys <= m_cur; end
                else if (m_cur != 0) begin m_st <= 1; m_c <= 0; end
                else m_st <= 0;
            end else if (m_st == 3 && read_done) begin
                m_st <= 0;
            end
        end
    end

    function automatic logic [5:0] exp_drive();
        logic [5:0] d;
        int ln;
        d = '0;
        if (m_st == 1) begin
            ln = (m_c % 288) / 48;
            if (m_valid(ln)) d[ln] = 1'b1;
        end else if (m_st != 2) begin
            for (int i = 0; i < 6; i++) d[i] = m_valid(i);
        end
        return d;
    endfunction

    always @(negedge clk) begin
        if (cmp_on && rst_n) begin
            chk("R1 drive", 32'(drive), 32'(exp_drive()));
            chk("R8 keys", 32'(keys), 32'(m_keys));
            chk("R2 req_n", 32'(req_n), 32'((m_st != 3) || host_cs));
            chk("R9 save_flag", 32'(save_flag), 32'(save_sel != 2'b00));
        end
    end

    // ---------------- stimulus ----------------
    task automatic press_wait(input logic [29:0] p, output int n);
        pressed = p;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (req_n && n < 8000);
    endtask

    task automatic read_out();
        pressed = '0;
        read_done = 1'b1;
        @(negedge clk);
        read_done = 1'b0;
        chk("R6 req released", 32'(req_n), 32'd1);
        @(negedge clk);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        int n;
        logic [29:0] kept;
        rst_n = 1'b0; read_done = 1'b0; host_cs = 1'b0;
        key_sel = 2'b00; save_sel = 2'b00; pressed = '0;
        repeat (4) @(negedge clk);
        // R11: reset state
        chk("R11 keys after reset", 32'(keys), 32'd0);
        chk("R11 req_n after reset", 32'(req_n), 32'd1);
        rst_n = 1'b1;
        @(negedge clk);
        cmp_on = 1'b1;
        chk("R9 idle levels normal", 32'(drive), 32'h3F);

        // R2 / R8: single clean press, KD8 = line 1 sense 2 -> bit 7
        press_wait(30'(1) << 7, n);
        chk("R2 request latency", 32'(n), 32'd578);
        chk("R8 bit mapping KD8", 32'(keys), 32'h80);
        chk("R5 drive idle while pending", 32'(drive), 32'h3F);

        // R5: sense changes while pending are ignored
        pressed = 30'(1) << 20;
        repeat (700) @(negedge clk);
        chk("R5 keys frozen", 32'(keys), 32'h80);
        chk("R5 request still low", 32'(req_n), 32'd0);

        // R10: chip enable hides the pending request
        host_cs = 1'b1;
        @(negedge clk);
        chk("R10 req high during frame", 32'(req_n), 32'd1);
        host_cs = 1'b0;
        @(negedge clk);
        chk("R10 req low after frame", 32'(req_n), 32'd0);
        read_out();

        // R6: read-done while idle does nothing
        read_done = 1'b1;
        @(negedge clk);
        read_done = 1'b0;
        repeat (3) @(negedge clk);
        chk("R6 stray read req_n", 32'(req_n), 32'd1);
        chk("R6 stray read keys", 32'(keys), 32'h80);

        // R3: bounce, first scan sees KD1, second scan sees KD2
        fork
            press_wait(30'(1) << 0, n);
            begin
                repeat (200) @(negedge clk);
                pressed = 30'(1) << 1;
            end
        join
        chk("R3 rescan latency", 32'(n), 32'd1155);
        chk("R3 keys after rescan", 32'(keys), 32'h2);
        read_out();

        // R4: key released before the second scan
        kept = keys;
        pressed = 30'(1) << 14;
        repeat (200) @(negedge clk);
        pressed = '0;
        repeat (800) @(negedge clk);
        chk("R4 no request on release", 32'(req_n), 32'd1);
        chk("R4 keys kept", 32'(keys), 32'(kept));

        // R7: 25 keys, line 0 unused
        key_sel = 2'b01;
        @(negedge clk);
        chk("R7 line0 low at 25 keys", 32'(drive), 32'h3E);
        pressed = 30'(1) << 2;
        repeat (700) @(negedge clk);
        chk("R7 unused line press ignored", 32'(req_n), 32'd1);
        press_wait((30'(1) << 2) | (30'(1) << 6), n);
        chk("R7 25-key result", 32'(keys), 32'h40);
        read_out();

        // R7: 20 keys, lines 0 and 1 unused
        key_sel = 2'b10;
        press_wait((30'(1) << 9) | (30'(1) << 10), n);
        chk("R7 20-key result", 32'(keys), 32'h400);
        read_out();
        key_sel = 2'b00;

        // R9: power-save 1, only line 5
        save_sel = 2'b01;
        @(negedge clk);
        chk("R9 save1 idle levels", 32'(drive), 32'h20);
        chk("R9 save1 flag", 32'(save_flag), 32'd1);
        press_wait((30'(1) << 20) | (30'(1) << 29), n);
        chk("R9 save1 keys", 32'(keys), 32'h2000_0000);
        read_out();

        // R9: power-save 2, lines 4 and 5
        save_sel = 2'b10;
        @(negedge clk);
        chk("R9 save2 idle levels", 32'(drive), 32'h30);
        press_wait((30'(1) << 20) | (30'(1) << 3), n);
        chk("R9 save2 keys", 32'(keys), 32'h0010_0000);
        read_out();

        // R9: power-save 3, all lines
        save_sel = 2'b11;
        @(negedge clk);
        chk("R9 save3 idle levels", 32'(drive), 32'h3F);
        save_sel = 2'b00;

        // R1: tick every third clock, multiple keys on several lines
        tick_div = 3;
        press_wait((30'(1) << 11) | (30'(1) << 27), n);
        chk("R1 gated scan keys", 32'(keys), 32'h0800_0800);
        chk("R1 gated latency longer", 32'(n > 1500), 32'd1);
        read_out();
        tick_div = 1;

        // R11: reset while pending clears the vector
        press_wait(30'(1) << 24, n);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R11 keys cleared", 32'(keys), 32'd0);
        chk("R11 req released", 32'(req_n), 32'd1);
        pressed = '0;
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        summary();
        $finish;
    end

endmodule